// File: doc/BRIEF.md
# Prescaled CPU-Cycle Interrupt Timer

This block is an 8-bit up-counting interrupt timer. Software loads an 8-bit reload value four bits at a time. It then writes a mode byte that starts the count. From that point the counter advances on CPU-cycle strobes. In raw mode it advances on every strobe. In line mode it advances through a prescaler that subtracts 3 per strobe from a budget of 341. This approximates one video scanline for every 113⅔ CPU cycles.

When the counter steps past its all-ones value, it reloads from the stored reload value and raises a level interrupt. The interrupt stays high until software writes either the mode register or the acknowledge register. The acknowledge write can also re-enable counting from a saved copy of the enable bit.

A separate `active_i` input gates all counting, so the timer can sit frozen while a surrounding design is in another mode. The caller decodes the CPU address into the two-bit register select.

Top module: `cyc_irq_timer`

## Requirements
- R1: A write with select 0 stores `wr_data_i[3:0]` into bits 3:0 of the reload value. A write with select 1 stores `wr_data_i[3:0]` into bits 7:4. The upper data nibble is ignored in both cases.
- R2: A write with select 2 clears the interrupt and stores the mode bits. Bit 0 is the saved enable, bit 1 is the enable and bit 2 selects raw mode. When bit 1 of the written data is 1, the same write loads the counter from the reload value and sets the prescaler to 341. When bit 1 is 0, the counter is not reloaded.
- R3: A write with select 3 clears the interrupt and copies mode bit 0 into mode bit 1. It leaves the counter and the prescaler unchanged.
- R4: In raw mode (mode bit 2 = 1) with the enable set, every CPU-cycle strobe advances the counter by one. With reload value L, the interrupt rises on strobe 256-L after the enabling mode write.
- R5: In line mode (mode bit 2 = 0) with the enable set, each strobe subtracts 3 from the signed prescaler. When the result is 0 or below, the counter advances and 341 is added to that result. After an enabling mode write with reload value L, the interrupt rises on strobe ceil(341·(256-L)/3).
- R6: A counter step taken at 0xFF loads the counter from the reload value and sets the interrupt. The interrupt is a level: further strobes leave it high until a write with select 2 or select 3.
- R7: Reset clears the reload value, mode, counter and prescaler and drops the interrupt. Enabling through select 3 straight after reset therefore starts from prescaler 0, and the first line-mode strobe advances the counter.
- R8: While `active_i` is low, strobes do not change the counter, the prescaler or the interrupt.
- R9: A cycle with `wr_en_i` high discards any strobe in the same cycle; only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active_i | input | 1 | Counting allowed while high |
| cpu_tick_i | input | 1 | One CPU-cycle strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select (0 low nibble, 1 high nibble, 2 mode, 3 acknowledge) |
| wr_data_i | input | 8 | Write data |
| irq_o | output | 1 | Level interrupt request |

## Verification
On every cycle, the assertions check the following:
- Mode and acknowledge writes clear the interrupt.
- An enabling mode write reloads the counter and prescaler.
- The prescaler stays within 0 to 341.
- Raw-mode strobes add exactly one.
- The interrupt rises only on a step taken at 0xFF.
- Inactive cycles and non-mode writes hold the counter.

Only the bench scenarios show the end-to-end strobe counts to the interrupt. These counts cover the 341/3 line cadence, the start from a zero prescaler after reset, and the re-arm and disable paths of the acknowledge write.

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer #(
  parameter int CNT_W      = 8,
  parameter int PRE_W      = 10,
  parameter int LINE_UNITS = 341,
  parameter int STEP_UNITS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic             cpu_tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             irq_o
);
  localparam int NIB = CNT_W / 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic signed [PRE_W-1:0] LINE_V = PRE_W'(LINE_UNITS);
  localparam logic signed [PRE_W-1:0] STEP_V = PRE_W'(STEP_UNITS);

  logic [CNT_W-1:0]        latch_q, cnt_q;
  logic [2:0]              mode_q;
  logic signed [PRE_W-1:0] pre_q, pre_dec;
  logic                    irq_q, run, step;

  assign run     = active_i && cpu_tick_i && !wr_en_i && mode_q[1];
  assign pre_dec = pre_q - STEP_V;
  assign step    = run && (mode_q[2] || pre_dec[PRE_W-1] || pre_dec == '0);
  assign irq_o   = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      cnt_q   <= '0;
      mode_q  <= '0;
      pre_q   <= '0;
      irq_q   <= 1'b0;
    end else if (wr_en_i) begin
      case (wr_sel_i)
        2'd0: latch_q[NIB-1:0]     <= wr_data_i[NIB-1:0];
        2'd1: latch_q[CNT_W-1:NIB] <= wr_data_i[NIB-1:0];
        2'd2: begin
          mode_q <= wr_data_i[2:0];
          irq_q  <= 1'b0;
          if (wr_data_i[1]) begin
            cnt_q <= latch_q;
            pre_q <= LINE_V;
          end
        end
        default: begin
          mode_q[1] <= mode_q[0];
          irq_q     <= 1'b0;
        end
      endcase
    end else if (run) begin
      if (!mode_q[2]) pre_q <= step ? pre_dec + LINE_V : pre_dec;
      if (step) begin
        if (cnt_q == CNT_MAX) begin
          cnt_q <= latch_q;
          irq_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cyc_irq_timer_chk.sv
module cyc_irq_timer_chk #(
  parameter int CNT_W      = 8,
  parameter int PRE_W      = 10,
  parameter int LINE_UNITS = 341
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    active_i,
  input logic                    cpu_tick_i,
  input logic                    wr_en_i,
  input logic [1:0]              wr_sel_i,
  input logic [CNT_W-1:0]        wr_data_i,
  input logic                    irq_o,
  input logic [CNT_W-1:0]        cnt_q,
  input logic [CNT_W-1:0]        latch_q,
  input logic [2:0]              mode_q,
  input logic signed [PRE_W-1:0] pre_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic signed [PRE_W-1:0] LINE_V = PRE_W'(LINE_UNITS);

  a_r2_mode_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && wr_sel_i == 2'd2 |=> !irq_o);

  a_r2_enable_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && wr_sel_i == 2'd2 && wr_data_i[1] |=> cnt_q == $past(latch_q) && pre_q == LINE_V);

  a_r3_ack_copies_enable: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && wr_sel_i == 2'd3 |=> !irq_o && mode_q[1] == $past(mode_q[0]));

  a_r4_raw_step: assert property (@(posedge clk) disable iff (!rst_n)
    active_i && cpu_tick_i && !wr_en_i && mode_q[1] && mode_q[2] && cnt_q != CNT_MAX
    |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

  a_r5_pre_range: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_q[PRE_W-1] && pre_q <= LINE_V);

  a_r6_irq_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(cnt_q) == CNT_MAX && cnt_q == latch_q && $past(mode_q[1]));

  a_r8_inactive_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !active_i && !wr_en_i |=> $stable(cnt_q) && $stable(pre_q) && $stable(irq_o));

  a_r9_write_drops_tick: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && wr_sel_i != 2'd2 |=> $stable(cnt_q) && $stable(pre_q));
endmodule

bind cyc_irq_timer cyc_irq_timer_chk #(
  .CNT_W(CNT_W), .PRE_W(PRE_W), .LINE_UNITS(LINE_UNITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .active_i(active_i), .cpu_tick_i(cpu_tick_i),
  .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .irq_o(irq_o),
  .cnt_q(cnt_q), .latch_q(latch_q), .mode_q(mode_q), .pre_q(pre_q)
);

// File: tb/cyc_irq_timer_bench.sv
module cyc_irq_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int NVEC       = 6;
  // {reload, mode, strobes to interrupt}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h00, 8'h07, 16'd256},   // R4 raw
    {8'hFF, 8'h07, 16'd1},     // R4 raw, immediate wrap
    {8'h80, 8'h07, 16'd128},   // R4 raw
    {8'hFF, 8'h03, 16'd114},   // R5 line, one step
    {8'hFE, 8'h03, 16'd228},   // R5 line, two steps
    {8'hF0, 8'h03, 16'd1819}   // R5 line, sixteen steps
  };

  logic       clk = 1'b0, rst_n = 1'b0, active = 1'b1, tick = 1'b0, wr_en = 1'b0;
  logic [1:0] sel = '0;
  logic [7:0] data = '0;
  logic       irq;
  int         n_chk = 0, n_fail = 0, cyc = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cyc_irq_timer u_cyc_irq_timer (
    .clk(clk), .rst_n(rst_n), .active_i(active), .cpu_tick_i(tick),
    .wr_en_i(wr_en), .wr_sel_i(sel), .wr_data_i(data), .irq_o(irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: irq=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; sel = s; data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic load(input logic [7:0] v);
    wr(2'd0, {4'h5, v[3:0]});
    wr(2'd1, {4'hA, v[7:4]});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 reset irq low", irq, 1'b0);
    ticks(10);
    chk("R7 mode zero after reset, no count", irq, 1'b0);

    // R7: enable via acknowledge copy, prescaler starts at zero
    wr(2'd2, 8'h01);
    wr(2'd3, 8'h00);
    ticks(28984);
    chk("R7 zero-prescaler start, before wrap", irq, 1'b0);
    ticks(1);
    chk("R7 zero-prescaler start, wrap", irq, 1'b1);

    for (int i = 0; i < NVEC; i++) begin
      load(VEC[i][31:24]);
      wr(2'd2, VEC[i][23:16]);
      chk("R2 mode write clears irq", irq, 1'b0);
      ticks(int'(VEC[i][15:0]) - 1);
      chk(VEC[i][18] ? "R4 raw one before wrap" : "R5 line one before wrap", irq, 1'b0);
      ticks(1);
      chk(VEC[i][18] ? "R4 raw wrap" : "R5 line wrap", irq, 1'b1);
    end

    // R1: upper data nibble ignored, reload 0xED -> 19 strobes
    wr(2'd0, 8'h3D);
    wr(2'd1, 8'hAE);
    wr(2'd2, 8'h07);
    ticks(18);
    chk("R1 nibble reload, before wrap", irq, 1'b0);
    ticks(1);
    chk("R1 nibble reload, wrap", irq, 1'b1);

    // R6 level + reload, R3 acknowledge keeps counting when saved bit set
    load(8'hF0);
    wr(2'd2, 8'h07);
    ticks(16);
    chk("R6 wrap raises irq", irq, 1'b1);
    ticks(3);
    chk("R6 irq stays high", irq, 1'b1);
    wr(2'd3, 8'h00);
    chk("R3 ack clears irq", irq, 1'b0);
    ticks(12);
    chk("R6 reload from latch, before second wrap", irq, 1'b0);
    ticks(1);
    chk("R6 second wrap after reload", irq, 1'b1);

    // R3: acknowledge with saved bit clear disables counting
    wr(2'd2, 8'h06);
    ticks(16);
    chk("R3 setup wrap", irq, 1'b1);
    wr(2'd3, 8'h00);
    chk("R3 ack clears irq", irq, 1'b0);
    ticks(300);
    chk("R3 ack disabled counting", irq, 1'b0);

    // R2: mode write without enable clears irq and stops counting
    wr(2'd2, 8'h07);
    ticks(16);
    chk("R2 setup wrap", irq, 1'b1);
    wr(2'd2, 8'h04);
    chk("R2 disabling write clears irq", irq, 1'b0);
    ticks(300);
    chk("R2 disabled, no count", irq, 1'b0);

    // R8: inactive freezes counting
    load(8'hFF);
    wr(2'd2, 8'h07);
    active = 1'b0;
    ticks(5);
    chk("R8 inactive ignores strobes", irq, 1'b0);
    active = 1'b1;
    ticks(1);
    chk("R8 resumes when active", irq, 1'b1);

    // R9: strobe coinciding with a write is dropped
    wr(2'd2, 8'h07);
    @(negedge clk); wr_en = 1'b1; sel = 2'd0; data = 8'h0F; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    chk("R9 strobe during write dropped", irq, 1'b0);
    ticks(1);
    chk("R9 next strobe counts", irq, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule